// File: doc/BRIEF.md
# Receive VLAN Tag Stripper

This block sits in a receive byte path, just after a MAC has delivered the destination and source addresses of a frame. It recognises one or two stacked 802.1Q tags that follow those addresses and removes them from the stream. Downstream receive buffers then see the real EtherType, such as 0x86DD for IPv6, right after the addresses. The removed tag control fields are reported on a sideband word, so software can still find out which virtual network a frame came from without reading them back out of the buffer.

The 12 address bytes pass straight through. The next bytes are held in a small window until the block can tell whether they form a tag, two stacked tags, or ordinary payload. The window is then replayed, minus any tag bytes, and the rest of the frame flows through. Both streams use valid/ready handshakes with a last marker. Backpressure is honoured in every phase.

Top module: `vlan_strip_rx`

## Requirements
- R1: After a synchronous reset, `m_valid` is low while `s_valid` is low, `tag_word` is 0, and both tag-present flags are 0.
- R2: The first 12 bytes of every frame are delivered unchanged and in order.
- R3: When stripping is on, a frame of at least 18 bytes whose bytes 12–13 are 0x81,0x00 loses bytes 12–15. Its 16-bit tag control field, taken from byte 14 (high) and byte 15 (low), is reported in `tag_word[15:0]`, with `tag_word[31:16]` = 0, `tag_outer_vld` = 1 and `tag_inner_vld` = 0. The control field is priority in bits 15:13, drop-eligible in bit 12 and VLAN ID in bits 11:0.
- R4: When stripping and double tagging are both on, a frame of at least 22 bytes is treated as a stacked pair if bytes 12–13 are 0x88A8 or 0x8100 and bytes 16–17 are 0x8100. Such a frame loses bytes 12–19. The outer control field (bytes 14–15) is reported in `tag_word[15:0]`, the inner one (bytes 18–19) in `tag_word[31:16]`, and both flags are set. A frame that does not qualify falls back to the R3 rule.
- R5: With double tagging off, only a 0x8100 outer tag is removed, and an inner tag stays in the stream. A frame starting with 0x88A8 alone is never altered.
- R6: When stripping is off, every frame is delivered unchanged, and `tag_word` and both flags keep their previous values.
- R7: When stripping is on and a frame carries no recognised tag, it is delivered unchanged and `tag_word` and both flags are cleared to 0. This covers frames with another EtherType, frames shorter than 18 bytes, and frames that end inside a tag.
- R8: No byte is lost or duplicated under any pattern of `m_ready`. While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values.
- R9: `tag_word` and the flags change only at the clock edge where an output byte with `m_last` set is accepted.
- R10: The stripping and double-tag settings are sampled when the first byte of a frame is accepted. Changing them later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strip_en | input | 1 | Enable tag removal |
| cfg_dbl_en | input | 1 | Enable stacked-pair removal |
| s_data | input | 8 | Input byte |
| s_valid | input | 1 | Input byte valid |
| s_last | input | 1 | Input byte is the last of its frame |
| s_ready | output | 1 | Block accepts the input byte |
| m_data | output | 8 | Output byte |
| m_valid | output | 1 | Output byte valid |
| m_last | output | 1 | Output byte is the last of its frame |
| m_ready | input | 1 | Downstream accepts the output byte |
| tag_word | output | 32 | Inner control field in 31:16, outer in 15:0 |
| tag_outer_vld | output | 1 | An outer tag was removed from the last frame |
| tag_inner_vld | output | 1 | An inner tag was removed from the last frame |

## Verification
A wrong window count or a wrong read index shows up within the same frame: output bytes after address byte 11 are dropped, repeated or shifted, and the last marker appears on the wrong byte. This is visible within a few cycles of the decision point. A wrong decode or a commit at the wrong moment shows up on the sideband word right after that frame's last output byte. A stale frame-level configuration shows up in the very next frame whose settings differ. The sweep covers every combination of configuration, tag layout and frame length around the 12-, 18- and 22-byte boundaries, with the downstream ready toggling throughout.

// File: rtl/vlan_strip_pkg.sv
package vlan_strip_pkg;

    localparam int unsigned ADDR_BYTES  = 12;
    localparam int unsigned TAG_BYTES   = 4;
    localparam int unsigned ETYPE_BYTES = 2;
    localparam int unsigned WIN_SGL     = TAG_BYTES + ETYPE_BYTES;
    localparam int unsigned WIN_MAX     = 2 * TAG_BYTES + ETYPE_BYTES;

    localparam logic [15:0] TPID_CTAG = 16'h8100;
    localparam logic [15:0] TPID_STAG = 16'h88A8;

    typedef enum logic [2:0] {
        ST_ADDR   = 3'd0,
        ST_FILL   = 3'd1,
        ST_DECIDE = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_BODY   = 3'd4
    } phase_t;

    typedef struct packed {
        logic [2:0]  pcp;
        logic        dei;
        logic [11:0] vid;
    } tci_t;

    typedef struct packed {
        logic [3:0] drop;
        tci_t       inner;
        tci_t       outer;
        logic       has_outer;
        logic       has_inner;
    } strip_res_t;

    function automatic logic [15:0] join16(input logic [7:0] hi, input logic [7:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/vs_hdr_window.sv
module vs_hdr_window #(
    parameter int unsigned DEPTH = vlan_strip_pkg::WIN_MAX,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    output logic [DEPTH-1:0][7:0] bytes_o,
    output logic [CW-1:0]         count_o
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count_q <= '0;
        else if (wr_en)
            count_q <= count_q + CW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                bytes_o[g] <= '0;
            else if (wr_en && count_q == CW'(g))
                bytes_o[g] <= wr_data;
        end
    end

    assign count_o = count_q;

    // R8
    win_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

endmodule

// File: rtl/vs_tag_decode.sv
module vs_tag_decode
    import vlan_strip_pkg::*;
#(
    parameter int unsigned DEPTH = WIN_MAX,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][7:0] win,
    input  logic [CW-1:0]         count,
    input  logic                  strip_en,
    input  logic                  dbl_en,
    output strip_res_t            res
);

    localparam logic [CW-1:0] NEED_SGL = CW'(WIN_SGL);
    localparam logic [CW-1:0] NEED_DBL = CW'(WIN_MAX);

    logic [15:0] tp_a, tp_b;
    logic        outer_ok, stacked, single;

    always_comb begin
        tp_a     = join16(win[0], win[1]);
        tp_b     = join16(win[4], win[5]);
        outer_ok = (tp_a == TPID_CTAG) || (tp_a == TPID_STAG);
        stacked  = strip_en && dbl_en && (count >= NEED_DBL) && outer_ok && (tp_b == TPID_CTAG);
        single   = strip_en && (count >= NEED_SGL) && (tp_a == TPID_CTAG);

        res = '0;
        if (stacked) begin
            res.drop      = 4'(2 * TAG_BYTES);
            res.outer     = tci_t'(join16(win[2], win[3]));
            res.inner     = tci_t'(join16(win[6], win[7]));
            res.has_outer = 1'b1;
            res.has_inner = 1'b1;
        end else if (single) begin
            res.drop      = 4'(TAG_BYTES);
            res.outer     = tci_t'(join16(win[2], win[3]));
            res.has_outer = 1'b1;
        end
    end

endmodule

// File: rtl/vs_tag_report.sv
module vs_tag_report (
    input  logic        clk,
    input  logic        rst,
    input  logic        commit,
    input  logic        enable,
    input  logic [31:0] word_in,
    input  logic        outer_in,
    input  logic        inner_in,
    output logic [31:0] tag_word,
    output logic        outer_vld,
    output logic        inner_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_word  <= '0;
            outer_vld <= 1'b0;
            inner_vld <= 1'b0;
        end else if (commit && enable) begin
            tag_word  <= word_in;
            outer_vld <= outer_in;
            inner_vld <= inner_in;
        end
    end

    // R4
    inner_needs_outer_chk: assert property (@(posedge clk) disable iff (rst)
        inner_vld |-> outer_vld);

    // R3
    hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !inner_vld |-> (tag_word[31:16] == 16'h0));

    // R7
    no_tag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !outer_vld |-> (tag_word == 32'h0));

endmodule

// File: rtl/vlan_strip_rx.sv
module vlan_strip_rx
    import vlan_strip_pkg::*;
#(
    parameter int unsigned ADDR_LEN = ADDR_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_strip_en,
    input  logic        cfg_dbl_en,
    input  logic [7:0]  s_data,
    input  logic        s_valid,
    input  logic        s_last,
    output logic        s_ready,
    output logic [7:0]  m_data,
    output logic        m_valid,
    output logic        m_last,
    input  logic        m_ready,
    output logic [31:0] tag_word,
    output logic        tag_outer_vld,
    output logic        tag_inner_vld
);

    localparam int unsigned WIN = WIN_MAX;
    localparam int unsigned CW  = $clog2(WIN + 1);
    localparam int unsigned AW  = $clog2(ADDR_LEN);

    phase_t              st;
    logic [AW-1:0]       addr_cnt;
    logic [CW-1:0]       rd_idx;
    logic                win_last;
    logic                strip_q, dbl_q;
    strip_res_t          res_q, res_c;

    logic [WIN-1:0][7:0] win_bytes;
    logic [CW-1:0]       win_count;

    logic first_beat, strip_eff, dbl_eff;
    logic s_acc, m_acc, win_wr, fill_done, commit;
    logic [CW-1:0] fill_target;
    logic [31:0]   commit_word;
    logic          commit_outer, commit_inner;

    assign first_beat  = (st == ST_ADDR) && (addr_cnt == '0);
    assign strip_eff   = first_beat ? cfg_strip_en : strip_q;
    assign dbl_eff     = first_beat ? cfg_dbl_en   : dbl_q;
    assign fill_target = dbl_eff ? CW'(WIN) : CW'(WIN_SGL);

    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_data  = 8'h00;
        m_last  = 1'b0;
        unique case (st)
            ST_ADDR, ST_BODY: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_data  = s_data;
                m_last  = s_last;
            end
            ST_FILL:   s_ready = 1'b1;
            ST_DECIDE: ;
            ST_DRAIN: begin
                m_valid = 1'b1;
                m_data  = win_bytes[rd_idx];
                m_last  = win_last && (rd_idx == win_count - CW'(1));
            end
            default: ;
        endcase
    end

    assign s_acc     = s_valid && s_ready;
    assign m_acc     = m_valid && m_ready;
    assign win_wr    = (st == ST_FILL) && s_valid;
    assign fill_done = win_wr && (s_last || (win_count + CW'(1) == fill_target));
    assign commit    = m_acc && m_last;

    always_comb begin
        if (st == ST_ADDR) begin
            commit_word  = '0;
            commit_outer = 1'b0;
            commit_inner = 1'b0;
        end else begin
            commit_word  = {res_q.inner, res_q.outer};
            commit_outer = res_q.has_outer;
            commit_inner = res_q.has_inner;
        end
    end

    vs_hdr_window #(.DEPTH(WIN), .CW(CW)) u_win (
        .clk     (clk),
        .rst     (rst),
        .clr     (st == ST_ADDR),
        .wr_en   (win_wr),
        .wr_data (s_data),
        .bytes_o (win_bytes),
        .count_o (win_count)
    );

    vs_tag_decode #(.DEPTH(WIN), .CW(CW)) u_dec (
        .win      (win_bytes),
        .count    (win_count),
        .strip_en (strip_q),
        .dbl_en   (dbl_q),
        .res      (res_c)
    );

    vs_tag_report u_rep (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .enable    (strip_eff),
        .word_in   (commit_word),
        .outer_in  (commit_outer),
        .inner_in  (commit_inner),
        .tag_word  (tag_word),
        .outer_vld (tag_outer_vld),
        .inner_vld (tag_inner_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_ADDR;
            addr_cnt <= '0;
            rd_idx   <= '0;
            win_last <= 1'b0;
            strip_q  <= 1'b0;
            dbl_q    <= 1'b0;
            res_q    <= '0;
        end else begin
            unique case (st)
                ST_ADDR: if (s_acc) begin
                    if (first_beat) begin
                        strip_q <= cfg_strip_en;
                        dbl_q   <= cfg_dbl_en;
                    end
                    if (s_last) begin
                        addr_cnt <= '0;
                    end else if (addr_cnt == AW'(ADDR_LEN - 1)) begin
                        addr_cnt <= '0;
                        st       <= ST_FILL;
                    end else begin
                        addr_cnt <= addr_cnt + AW'(1);
                    end
                end
                ST_FILL: if (fill_done) begin
                    win_last <= s_last;
                    st       <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    res_q  <= res_c;
                    rd_idx <= CW'(res_c.drop);
                    st     <= ST_DRAIN;
                end
                ST_DRAIN: if (m_ready) begin
                    if (rd_idx == win_count - CW'(1))
                        st <= win_last ? ST_ADDR : ST_BODY;
                    else
                        rd_idx <= rd_idx + CW'(1);
                end
                ST_BODY: if (s_acc && s_last) st <= ST_ADDR;
                default: st <= ST_ADDR;
            endcase
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R9
    tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(m_valid && m_ready && m_last) |=>
            ($stable(tag_word) && $stable(tag_outer_vld) && $stable(tag_inner_vld)));

endmodule

// File: tb/vlan_strip_rx_bench.sv
module vlan_strip_rx_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_strip_en, cfg_dbl_en;
    logic [7:0]  s_data;
    logic        s_valid, s_last, s_ready;
    logic [7:0]  m_data;
    logic        m_valid, m_last, m_ready;
    logic [31:0] tag_word;
    logic        tag_outer_vld, tag_inner_vld;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  fb [0:63];
    logic [7:0]  eb [0:63];
    logic [31:0] exp_w = '0;
    logic        exp_o = 1'b0, exp_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlan_strip_rx u_vlan_strip_rx (
        .clk(clk), .rst(rst),
        .cfg_strip_en(cfg_strip_en), .cfg_dbl_en(cfg_dbl_en),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
        .tag_word(tag_word), .tag_outer_vld(tag_outer_vld), .tag_inner_vld(tag_inner_vld)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic put16(input int pos, input int len, input logic [15:0] v);
        if (pos < len)     fb[pos]     = v[15:8];
        if (pos + 1 < len) fb[pos + 1] = v[7:0];
    endtask

    function automatic logic [15:0] rd16(input int pos);
        return {fb[pos], fb[pos + 1]};
    endfunction

    // kinds: 0 none, 1 single, 2 ctag/ctag, 3 stag/ctag, 4 lone stag, 5 ctag then stag
    task automatic run_frame(input bit st, input bit db, input int kind, input int len, input bit flip);
        logic [15:0] t1, t2;
        int          drop, elen, idx, oidx, cyc, bad;
        bit          done;
        string       tag;
        logic [31:0] nw;
        logic        no, ni;

        t1 = 16'h0301 + 16'(len);
        t2 = 16'h3001 + 16'(kind);
        for (int i = 0; i < len; i++) fb[i] = 8'((i * 37 + len * 11 + kind) & 255);
        case (kind)
            0: put16(12, len, 16'h86DD);
            1: begin put16(12, len, 16'h8100); put16(14, len, t1); put16(16, len, 16'h86DD); end
            2: begin put16(12, len, 16'h8100); put16(14, len, t1); put16(16, len, 16'h8100);
                     put16(18, len, t2); put16(20, len, 16'h86DD); end
            3: begin put16(12, len, 16'h88A8); put16(14, len, t1); put16(16, len, 16'h8100);
                     put16(18, len, t2); put16(20, len, 16'h86DD); end
            4: begin put16(12, len, 16'h88A8); put16(14, len, t1); put16(16, len, 16'h86DD); end
            default: begin put16(12, len, 16'h8100); put16(14, len, t1); put16(16, len, 16'h88A8);
                     put16(18, len, t2); put16(20, len, 16'h86DD); end
        endcase

        // expected behaviour from the requirements
        drop = 0; nw = '0; no = 1'b0; ni = 1'b0;
        if (!st) tag = "R6";
        else if (db && len >= 22 && (rd16(12) == 16'h8100 || rd16(12) == 16'h88A8) && rd16(16) == 16'h8100) begin
            drop = 8; nw = {rd16(18), rd16(14)}; no = 1'b1; ni = 1'b1; tag = "R4";
        end else if (len >= 18 && rd16(12) == 16'h8100) begin
            drop = 4; nw = {16'h0, rd16(14)}; no = 1'b1; tag = (!db && kind == 2) ? "R5" : "R3";
        end else tag = (!db && (kind == 3 || kind == 4)) ? "R5" : "R7";
        if (flip) tag = "R10";
        elen = len - drop;
        for (int i = 0; i < elen; i++) eb[i] = (i < 12) ? fb[i] : fb[i + drop];

        @(negedge clk);
        cfg_strip_en = st; cfg_dbl_en = db;
        idx = 0; oidx = 0; cyc = 0; bad = 0; done = 0;
        while (!done && cyc < 2000) begin
            if (cyc > 0) @(negedge clk);
            if (flip && idx >= 2) begin cfg_strip_en = !st; cfg_dbl_en = !db; end
            s_valid = (idx < len);
            s_data  = (idx < len) ? fb[idx] : 8'h00;
            s_last  = (idx == len - 1);
            m_ready = ((cyc * 5 + len + kind) % 4) != 0;
            #1;
            if (m_valid && m_ready) begin
                if (oidx == 1)  // R9: sideband unchanged mid-frame
                    check(tag_word == exp_w && tag_outer_vld == exp_o && tag_inner_vld == exp_i,
                          "R9", {32'h0, tag_word}, {32'h0, exp_w});
                if (oidx >= elen || m_data !== eb[oidx] || m_last !== (oidx == elen - 1)) begin
                    bad++;
                    if (bad == 1)
                        $display("FAIL %s%s byte %0d (R8 stalls) actual=%0h/%0b expected=%0h/%0b",
                                 (oidx < 12) ? "R2 " : "", tag, oidx, m_data, m_last,
                                 (oidx < elen) ? eb[oidx] : 8'hxx, (oidx == elen - 1));
                end
                if (m_last) done = 1;
                oidx++;
            end
            if (s_valid && s_ready) idx++;
            cyc++;
        end
        n_checks++;
        if (bad != 0 || oidx != elen) begin
            n_fails++;
            if (bad == 0) $display("FAIL %s count actual=%0d expected=%0d", tag, oidx, elen);
        end

        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        cfg_strip_en = st; cfg_dbl_en = db;
        if (st) begin exp_w = nw; exp_o = no; exp_i = ni; end
        #1;
        check(tag_word == exp_w && tag_outer_vld == exp_o && tag_inner_vld == exp_i, tag,
              {30'h0, tag_outer_vld, tag_inner_vld, tag_word}, {30'h0, exp_o, exp_i, exp_w});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int lens [13] = '{1, 5, 12, 13, 14, 16, 17, 18, 19, 21, 22, 23, 30};
        rst = 1'b1; cfg_strip_en = 1'b0; cfg_dbl_en = 1'b0;
        s_valid = 1'b0; s_last = 1'b0; s_data = 8'h00; m_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1
        check(!m_valid && tag_word == 32'h0 && !tag_outer_vld && !tag_inner_vld, "R1",
              {31'h0, m_valid, tag_word}, 64'h0);

        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 6; k++)
                for (int l = 0; l < 13; l++)
                    run_frame(c[1], c[0], k, lens[l], 1'b0);

        // R10: settings flipped after the second input byte
        for (int c = 0; c < 4; c++)
            for (int k = 1; k < 4; k++)
                run_frame(c[1], c[0], k, 26, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule